// File: doc/BRIEF.md
# Indexed-Access Watchdog Timer

This block is a countdown watchdog that software reaches through a two-byte I/O window. Offset 0 holds a register index and offset 1 reads or writes the 8-bit register that the index selects. Behind the window are an enable control, an expiry-action select, a 24-bit timeout split over three bytes, and a control byte that carries a reload strobe and a sticky fired flag.

The counter steps down only on cycles where the single-cycle 32768 Hz tick enable is high while the timer is enabled. A programmed value N gives N+1 ticks before expiry. When it expires, the block sets the fired flag, reloads itself and keeps running. Depending on the select nibble it also emits a one-cycle NMI pulse or holds a system reset request high for a fixed number of clocks. Software keeps the system alive by writing the reload strobe before the count runs out.

Top module: `wdt_indexed`

## Requirements
- R1: A write at offset 0 (`bus_addr_i`=0) stores the register index, and a read at offset 0 returns it. Offset 1 reads and writes the register named by the stored index. Reads have no side effects.
- R2: Index 0x37 is the control byte. All 8 bits are stored and read back, and bit 6 enables counting. The counter changes only on clocks where `tick_i` is high and bit 6 is set. While bit 6 is clear, ticks never cause an expiry.
- R3: Index 0x38 is the expiry select, stored and read back in full, and its upper nibble chooses the action. With 0xC, expiry gives an `nmi_o` pulse exactly one clock long, in the clock after the expiring tick, and `sysrst_o` stays low.
- R4: The 24-bit timeout value is held as low byte at index 0x39, middle byte at 0x3A and upper byte at 0x3B, each read back as written.
- R5: With timeout value N loaded, expiry happens on the (N+1)-th enabled tick, and not before.
- R6: Index 0x3C bit 6 is a reload strobe. Writing it as 1 restarts the count from the timeout value, and it always reads as 0. Bits 5..0 of 0x3C are plain storage.
- R7: Index 0x3C bit 7 is the fired flag. Expiry sets it. A write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged. When expiry and a clearing write fall in the same clock, the flag ends up set.
- R8: With select nibble 0xD, expiry drives `sysrst_o` high for exactly 4 clocks (parameter RST_HOLD), and `nmi_o` stays low.
- R9: With any select nibble other than 0xC or 0xD, expiry drives neither output but still sets the fired flag.
- R10: After expiry the counter reloads from the timeout value and keeps counting while enabled. A write that changes control bit 6 from 0 to 1 also loads the timeout value.
- R11: Indices other than 0x37 to 0x3C read as 0x00, and writes to them change no register.
- R12: Reset clears every register, the fired flag and both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle 32768 Hz count enable |
| bus_wr_i | input | 1 | Write strobe for the I/O window |
| bus_addr_i | input | 1 | Window offset: 0 index, 1 data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected offset |
| nmi_o | output | 1 | One-clock NMI request on expiry |
| sysrst_o | output | 1 | Held system reset request on expiry |

## Verification
Two events can land on the fired flag in the same clock. One is the counter reaching zero on a tick, which sets the flag. The other is a software write to index 0x3C with bit 7 clear, which clears it. The bench lines these up by loading a zero timeout, pointing the index at 0x3C and then, in a single clock, raising `tick_i` and writing 0x00 to offset 1. It then reads the flag back through the window and expects it set. In the same run the select nibble is 0x5, so the bench also confirms that neither output moved.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register indices seen through the data port
  localparam logic [7:0] IDX_CTRL = 8'h37;
  localparam logic [7:0] IDX_SEL  = 8'h38;
  localparam logic [7:0] IDX_TMO0 = 8'h39;
  localparam logic [7:0] IDX_CTL1 = 8'h3C;

  localparam int EN_BIT    = 6;
  localparam int RLD_BIT   = 6;
  localparam int FIRED_BIT = 7;

  localparam logic [3:0] SEL_NMI = 4'hC;
  localparam logic [3:0] SEL_RST = 4'hD;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_RST  = 2'd2
  } expiry_act_e;

  function automatic expiry_act_e decode_sel(input logic [3:0] nib);
    case (nib)
      SEL_NMI: return ACT_NMI;
      SEL_RST: return ACT_RST;
      default: return ACT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             expire_i,
  output logic             ctrl_en_o,
  output logic [3:0]       sel_nib_o,
  output logic [TMO_W-1:0] tmo_o,
  output logic             load_o,
  output logic             fired_o
);

  localparam int NB = TMO_W / 8;

  logic [7:0] idx_q, ctrl_q, sel_q;
  logic [5:0] ctl1_lo_q;
  logic       fired_q;
  logic [7:0] tmo_b [NB];
  logic       wr_data;

  assign wr_data = bus_wr && bus_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ctrl_q    <= '0;
      sel_q     <= '0;
      ctl1_lo_q <= '0;
      fired_q   <= 1'b0;
    end else begin
      if (bus_wr && !bus_addr)             idx_q     <= bus_wdata;
      if (wr_data && idx_q == IDX_CTRL)    ctrl_q    <= bus_wdata;
      if (wr_data && idx_q == IDX_SEL)     sel_q     <= bus_wdata;
      if (wr_data && idx_q == IDX_CTL1)    ctl1_lo_q <= bus_wdata[5:0];
      // expiry wins over a clearing write in the same clock
      if (expire_i)
        fired_q <= 1'b1;
      else if (wr_data && idx_q == IDX_CTL1 && !bus_wdata[FIRED_BIT])
        fired_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_tmo
    always_ff @(posedge clk) begin
      if (!rst_n)
        tmo_b[b] <= '0;
      else if (wr_data && idx_q == IDX_TMO0 + 8'(b))
        tmo_b[b] <= bus_wdata;
    end
    assign tmo_o[b*8 +: 8] = tmo_b[b];
  end

  // enable rising through a write, or the reload strobe
  assign load_o = wr_data &&
                  ((idx_q == IDX_CTRL && bus_wdata[EN_BIT] && !ctrl_q[EN_BIT]) ||
                   (idx_q == IDX_CTL1 && bus_wdata[RLD_BIT]));

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_addr) begin
      bus_rdata = idx_q;
    end else begin
      if (idx_q == IDX_CTRL) bus_rdata = ctrl_q;
      if (idx_q == IDX_SEL)  bus_rdata = sel_q;
      if (idx_q == IDX_CTL1) bus_rdata = {fired_q, 1'b0, ctl1_lo_q};
      for (int b = 0; b < NB; b++)
        if (idx_q == IDX_TMO0 + 8'(b)) bus_rdata = tmo_b[b];
    end
  end

  assign ctrl_en_o = ctrl_q[EN_BIT];
  assign sel_nib_o = sel_q[7:4];
  assign fired_o   = fired_q;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             load,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire_o,
  output logic [TMO_W-1:0] cnt_o
);

  logic [TMO_W-1:0] cnt_q;

  function automatic logic [TMO_W-1:0] step(input logic [TMO_W-1:0] cur,
                                            input logic [TMO_W-1:0] top);
    return (cur == '0) ? top : cur - TMO_W'(1);
  endfunction

  assign expire_o = en && tick && !load && cnt_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= tmo;
    else if (en && tick)
      cnt_q <= step(cnt_q, tmo);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_outs.sv
module wdt_outs
  import wdt_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic [3:0] sel_nib,
  output logic       nmi_o,
  output logic       sysrst_o
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  expiry_act_e     act;
  logic            nmi_q;
  logic [HOLD_W-1:0] hold_q;

  assign act = decode_sel(sel_nib);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      nmi_q <= expire && act == ACT_NMI;
      if (expire && act == ACT_RST)
        hold_q <= HOLD_W'(RST_HOLD);
      else if (hold_q != '0)
        hold_q <= hold_q - HOLD_W'(1);
    end
  end

  assign nmi_o    = nmi_q;
  assign sysrst_o = hold_q != '0;

endmodule

// File: rtl/wdt_indexed.sv
module wdt_indexed #(
  parameter int TMO_W    = 24,
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_wr_i,
  input  logic       bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       nmi_o,
  output logic       sysrst_o
);

  logic             ctrl_en;
  logic [3:0]       sel_nib;
  logic [TMO_W-1:0] tmo_val;
  logic             load_evt;
  logic             expire_evt;
  logic [TMO_W-1:0] cnt_val;
  logic             fired;

  wdt_regs #(.TMO_W(TMO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .expire_i  (expire_evt),
    .ctrl_en_o (ctrl_en),
    .sel_nib_o (sel_nib),
    .tmo_o     (tmo_val),
    .load_o    (load_evt),
    .fired_o   (fired)
  );

  wdt_count #(.TMO_W(TMO_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .en       (ctrl_en),
    .load     (load_evt),
    .tmo      (tmo_val),
    .expire_o (expire_evt),
    .cnt_o    (cnt_val)
  );

  wdt_outs #(.RST_HOLD(RST_HOLD)) u_outs (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire_evt),
    .sel_nib  (sel_nib),
    .nmi_o    (nmi_o),
    .sysrst_o (sysrst_o)
  );

endmodule

// File: rtl/wdt_indexed_chk.sv
module wdt_indexed_chk #(
  parameter int TMO_W    = 24,
  parameter int RST_HOLD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic             load_evt,
  input logic             expire_evt,
  input logic [TMO_W-1:0] cnt_val,
  input logic [TMO_W-1:0] tmo_val,
  input logic             fired,
  input logic             nmi_o,
  input logic             sysrst_o
);

  int unsigned hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n)        hi_len <= 0;
    else if (sysrst_o) hi_len <= hi_len + 1;
    else               hi_len <= 0;
  end

  AST_NMI_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> $past(expire_evt)); // R3

  AST_FIRED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> fired); // R7

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !load_evt) |=> $stable(cnt_val)); // R2

  AST_RELOAD_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> cnt_val == $past(tmo_val)); // R10

  AST_LOAD_TAKES_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_val == $past(tmo_val)); // R6

  AST_RESET_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysrst_o) |-> hi_len >= RST_HOLD); // R8

endmodule

bind wdt_indexed wdt_indexed_chk #(.TMO_W(TMO_W), .RST_HOLD(RST_HOLD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_en    (ctrl_en),
  .load_evt   (load_evt),
  .expire_evt (expire_evt),
  .cnt_val    (cnt_val),
  .tmo_val    (tmo_val),
  .fired      (fired),
  .nmi_o      (nmi_o),
  .sysrst_o   (sysrst_o)
);

// File: tb/tb_wdt_indexed.sv
`timescale 1ns/1ps
module tb_wdt_indexed;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic       bus_addr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       nmi_o;
  logic       sysrst_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdt_indexed dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .nmi_o       (nmi_o),
    .sysrst_o    (sysrst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] idx);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = 1'b0; bus_wdata_i = idx;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    set_idx(idx);
    bus_wr_i = 1'b1; bus_addr_i = 1'b1; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
    set_idx(idx);
    bus_addr_i = 1'b1;
    #1 d = bus_rdata_o;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_timeout(input logic [23:0] v);
    wr_reg(8'h39, v[7:0]);
    wr_reg(8'h3A, v[15:8]);
    wr_reg(8'h3B, v[23:16]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R12 nmi after reset", nmi_o, 0);
    check("R12 sysrst after reset", sysrst_o, 0);
    rd_reg(8'h37, d); check("R12 ctrl after reset", d, 8'h00);
    rd_reg(8'h38, d); check("R12 select after reset", d, 8'h00);
    rd_reg(8'h3B, d); check("R12 timeout hi after reset", d, 8'h00);
    rd_reg(8'h3C, d); check("R12 ctl1 after reset", d, 8'h00);
  endtask

  task automatic t_access();
    logic [7:0] d;
    set_idx(8'hA5);
    bus_addr_i = 1'b0; #1 check("R1 index readback", bus_rdata_o, 8'hA5);
    set_timeout(24'h563412);
    rd_reg(8'h39, d); check("R4 timeout low byte", d, 8'h12);
    rd_reg(8'h3A, d); check("R4 timeout mid byte", d, 8'h34);
    rd_reg(8'h3B, d); check("R4 timeout high byte", d, 8'h56);
    wr_reg(8'h38, 8'hC5);
    rd_reg(8'h38, d); check("R3 select full byte", d, 8'hC5);
    wr_reg(8'h37, 8'h15);
    rd_reg(8'h37, d); check("R2 ctrl readback", d, 8'h15);
    wr_reg(8'h3D, 8'h40);
    rd_reg(8'h3D, d); check("R11 unimplemented 0x3D", d, 8'h00);
    wr_reg(8'h36, 8'hFF);
    rd_reg(8'h36, d); check("R11 unimplemented 0x36", d, 8'h00);
    rd_reg(8'h37, d); check("R11 ctrl untouched", d, 8'h15);
    rd_reg(8'h3C, d); check("R11 ctl1 untouched", d, 8'h00);
  endtask

  task automatic t_nmi_timing();
    logic [7:0] d;
    set_timeout(24'h000003);
    wr_reg(8'h38, 8'hC0);
    wr_reg(8'h37, 8'h40);
    for (int i = 1; i <= 4; i++) begin
      pulse_tick();
      check("R5 expiry on tick N+1", nmi_o, (i == 4));
      check("R3 no reset on nmi select", sysrst_o, 0);
    end
    @(negedge clk);
    check("R3 nmi one clock", nmi_o, 0);
    rd_reg(8'h3C, d); check("R7 fired set", d, 8'h80);
    for (int i = 1; i <= 4; i++) begin
      pulse_tick();
      check("R10 rerun after expiry", nmi_o, (i == 4));
    end
  endtask

  task automatic t_gating();
    logic [7:0] d;
    wr_reg(8'h3C, 8'h40);
    pulse_tick(); pulse_tick();
    repeat (30) @(negedge clk);
    check("R2 idle clocks no expiry", nmi_o, 0);
    pulse_tick(); check("R2 third tick", nmi_o, 0);
    pulse_tick(); check("R2 fourth tick expires", nmi_o, 1);
    wr_reg(8'h3C, 8'h00);
    wr_reg(8'h37, 8'h15);
    for (int i = 0; i < 10; i++) begin
      pulse_tick();
      check("R2 disabled no nmi", nmi_o, 0);
    end
    rd_reg(8'h3C, d); check("R2 disabled fired clear", d, 8'h00);
    wr_reg(8'h37, 8'h40);
    for (int i = 1; i <= 4; i++) begin
      pulse_tick();
      check("R10 enable rise loads", nmi_o, (i == 4));
    end
  endtask

  task automatic t_reload();
    logic [7:0] d;
    wr_reg(8'h3C, 8'h40);
    pulse_tick(); pulse_tick(); pulse_tick();
    wr_reg(8'h3C, 8'h40);
    for (int i = 1; i <= 4; i++) begin
      pulse_tick();
      check("R6 strobe restarts count", nmi_o, (i == 4));
    end
    wr_reg(8'h3C, 8'hFF);
    rd_reg(8'h3C, d); check("R6 strobe reads 0", d, 8'hBF);
  endtask

  task automatic t_fired();
    logic [7:0] d;
    wr_reg(8'h3C, 8'h80);
    rd_reg(8'h3C, d); check("R7 write 1 keeps flag", d[7], 1);
    wr_reg(8'h3C, 8'h00);
    rd_reg(8'h3C, d); check("R7 write 0 clears", d, 8'h00);
    wr_reg(8'h3C, 8'h80);
    rd_reg(8'h3C, d); check("R7 write 1 does not set", d[7], 0);
    wr_reg(8'h3C, 8'h00);
  endtask

  task automatic t_sysrst();
    int hi;
    set_timeout(24'h000000);
    wr_reg(8'h38, 8'hD0);
    wr_reg(8'h3C, 8'h40);
    pulse_tick();
    hi = sysrst_o ? 1 : 0;
    check("R8 nmi stays low", nmi_o, 0);
    repeat (6) begin
      @(negedge clk);
      if (sysrst_o) hi++;
    end
    check("R8 reset hold clocks", hi, 4);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr_reg(8'h3C, 8'h00);
    wr_reg(8'h38, 8'h50);
    wr_reg(8'h3C, 8'h40);
    set_idx(8'h3C);
    bus_wr_i = 1'b1; bus_addr_i = 1'b1; bus_wdata_i = 8'h00; tick_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; tick_i = 1'b0;
    check("R9 no nmi on other select", nmi_o, 0);
    check("R9 no reset on other select", sysrst_o, 0);
    rd_reg(8'h3C, d); check("R7 expiry beats clear", d, 8'h80);
    pulse_tick();
    check("R9 repeat no nmi", nmi_o, 0);
    check("R9 repeat no reset", sysrst_o, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_access();
    t_nmi_timing();
    t_gating();
    t_reload();
    t_fired();
    t_sysrst();
    t_collision();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule